// File: doc/BRIEF.md
# Decimal Accumulator Processor

A small multicycle processor whose machine words are three-digit decimal codes held in binary. The hundreds digit selects the operation. The low two digits name one of 100 locations in a single memory that holds both program and data. The machine steps through explicit register transfers between a program counter, an address register, a data register, an instruction register and a signed accumulator. Each instruction spends two cycles being fetched and then one or two cycles being executed.

A value enters the accumulator through an input port using a request/valid handshake. The machine waits as long as needed for the value. Results leave through an output port that carries a one-cycle strobe. A preload port writes memory words while the machine is held in reset, which is how a program and its data get loaded. The machine raises a halted flag when it stops.

Top module: `dac_cpu`

## Requirements
- R1: While reset is applied, and after it is released, `halted`, `out_valid` and `in_req` are 0. The program counter and the accumulator start at 0, so the first instruction is taken from address 00.
- R2: Each instruction is fetched in two cycles. In the first cycle the address register takes the PC and the word is read into the data register. In the second cycle the instruction register takes the data register and the PC advances by one, wrapping from 99 to 00. A single-step execute therefore makes instructions three cycles apart.
- R3: Code 901 drives `in_req` high and holds the machine in its execute step until `in_valid` is 1. It then loads `in_value` into the accumulator, limited to at most 999, and continues.
- R4: Code 902 places the accumulator on `out_value` and pulses `out_valid` high for exactly one cycle.
- R5: Opcode 1 (add) and opcode 2 (subtract) each take two execute steps. The first step reads the addressed word. The second step adds the word to the accumulator or subtracts it, and the result saturates to the range -999..+999. An instruction of this kind spans four cycles.
- R6: Opcode 3 (store) takes one execute step and writes the accumulator to the addressed word. A negative value is stored as 1000 plus the value, so -3 is stored as 997.
- R7: Opcode 5 (load) takes two execute steps and copies the addressed word, 0..999, into the accumulator.
- R8: Opcode 8 takes one execute step. It sets the PC to the address field when the accumulator is 0 or more. Otherwise it leaves the already incremented PC unchanged.
- R9: Code 000, opcodes 4, 6 and 7, and any 9xx code other than 901 and 902 halt the machine. `halted` then stays 1 until reset, and no further output strobe or input request occurs.
- R10: While reset is applied, a cycle with `pl_we` high writes `pl_data` to the word at `pl_addr`.
- R11: The program 901 310 901 311 210 808 510 211 902 000 outputs exactly one value, 202, and then halts. This holds whether the inputs are 102 then 304 or 304 then 102.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_value | input | 10 | Value offered to the accumulator |
| in_valid | input | 1 | `in_value` is present this cycle |
| in_req | output | 1 | Machine is waiting on an input instruction |
| out_value | output | 11 | Signed accumulator copy from the last output instruction |
| out_valid | output | 1 | One-cycle strobe for `out_value` |
| halted | output | 1 | Machine has stopped |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 7 | Preload word address, 0..99 |
| pl_data | input | 10 | Preload word value, 0..999 |

## Verification
The bench measures the gaps between output strobes. This exposes a design that fetches in the wrong number of cycles, or that runs add, store or branch with the wrong number of execute steps. Saturation is driven from both ends, and a design that wraps would output a value of the opposite sign. A branch is placed at address 99 so that the fall-through path must wrap to 00. A design that does not wrap, or that branches on a negative accumulator, would lose the expected -5 or loop forever. The bench also stores a negative value and reads it back, delays inputs across several cycles, and runs unlisted opcodes. A design that got these wrong would output a corrupted value, would load a stale input, or would keep executing after a halt.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic [2:0] {
    ST_F1,
    ST_F2,
    ST_X1,
    ST_X2,
    ST_HALT
  } dac_state_e;

  typedef enum logic [2:0] {
    OP_HALT,
    OP_ADD,
    OP_SUB,
    OP_STORE,
    OP_LOAD,
    OP_BRGE,
    OP_IN,
    OP_OUT
  } dac_op_e;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end
endmodule

// File: rtl/dac_mem.sv
module dac_mem #(
  parameter int DEPTH  = 100,
  parameter int WORD_W = 10,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) begin
      cells[waddr] <= wdata;
    end
  end

  always_comb begin
    if (32'(raddr) < DEPTH) rdata = cells[raddr];
    else                    rdata = '0;
  end
endmodule

// File: rtl/dac_decode.sv
module dac_decode
  import dac_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int ADDR_W = 7,
  parameter int SPAN   = 100
) (
  input  logic [WORD_W-1:0] ir,
  output dac_op_e           op,
  output logic [ADDR_W-1:0] addr
);
  logic [31:0] lead;
  logic [31:0] low;

  always_comb begin
    lead = 32'(ir) / SPAN;
    low  = 32'(ir) % SPAN;
    addr = ADDR_W'(low);
    unique case (lead)
      32'd1:   op = OP_ADD;
      32'd2:   op = OP_SUB;
      32'd3:   op = OP_STORE;
      32'd5:   op = OP_LOAD;
      32'd8:   op = OP_BRGE;
      32'd9:   op = (low == 32'd1) ? OP_IN : ((low == 32'd2) ? OP_OUT : OP_HALT);
      default: op = OP_HALT;
    endcase
  end
endmodule

// File: rtl/dac_alu.sv
module dac_alu #(
  parameter int ACC_W  = 11,
  parameter int WORD_W = 10,
  parameter int LIMIT  = 999
) (
  input  logic signed [ACC_W-1:0]  acc,
  input  logic        [WORD_W-1:0] operand,
  input  logic                     sub,
  output logic signed [ACC_W-1:0]  result
);
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] HI = EXT_W'(LIMIT);
  localparam logic signed [EXT_W-1:0] LO = -HI;

  logic signed [EXT_W-1:0] a_x;
  logic signed [EXT_W-1:0] b_x;
  logic signed [EXT_W-1:0] raw;

  always_comb begin
    a_x = EXT_W'(acc);
    b_x = $signed(EXT_W'(operand));
    raw = sub ? (a_x - b_x) : (a_x + b_x);
    if (raw > HI)      result = ACC_W'(HI);
    else if (raw < LO) result = ACC_W'(LO);
    else               result = ACC_W'(raw);
  end
endmodule

// File: rtl/dac_cpu.sv
module dac_cpu
  import dac_pkg::*;
#(
  parameter int MEM_DEPTH = 100,
  parameter int WORD_W    = 10,
  parameter int ADDR_W    = 7,
  parameter int ACC_W     = 11,
  parameter int LIMIT     = 999
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       in_value,
  input  logic                    in_valid,
  output logic                    in_req,
  output logic signed [ACC_W-1:0] out_value,
  output logic                    out_valid,
  output logic                    halted,
  input  logic                    pl_we,
  input  logic [ADDR_W-1:0]       pl_addr,
  input  logic [WORD_W-1:0]       pl_data
);
  localparam int WORD_MOD = LIMIT + 1;

  logic rst_sync_n;

  dac_state_e state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, mar_q, mar_d;
  logic [WORD_W-1:0] mdr_q, mdr_d, ir_q;
  logic signed [ACC_W-1:0] acc_q, acc_d, alu_res, out_q;
  logic pc_en, mar_en, mdr_en, ir_en, acc_en, out_en;
  logic out_valid_q, out_valid_d, wr_pend_q, wr_pend_d, alu_sub;

  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [WORD_W-1:0] mem_rdata, mem_wdata, store_word;
  logic              mem_we;
  dac_op_e           dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic signed [31:0] acc_wide;

  function automatic logic [WORD_W-1:0] clip(input logic [WORD_W-1:0] w);
    return (32'(w) > LIMIT) ? WORD_W'(LIMIT) : w;
  endfunction

  dac_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dac_mem #(.DEPTH(MEM_DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  dac_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SPAN(MEM_DEPTH)) u_decode (
    .ir   (ir_q),
    .op   (dec_op),
    .addr (dec_addr)
  );

  dac_alu #(.ACC_W(ACC_W), .WORD_W(WORD_W), .LIMIT(LIMIT)) u_alu (
    .acc     (acc_q),
    .operand (mdr_q),
    .sub     (alu_sub),
    .result  (alu_res)
  );

  // preload has priority; a pending store lands from MAR/MDR one cycle after execute
  assign mem_we    = pl_we | wr_pend_q;
  assign mem_waddr = pl_we ? pl_addr : mar_q;
  assign mem_wdata = pl_we ? pl_data : mdr_q;

  assign pc_inc   = (32'(pc_q) == MEM_DEPTH - 1) ? '0 : pc_q + 1'b1;
  assign acc_wide = 32'(acc_q);
  assign store_word = WORD_W'(acc_q[ACC_W-1] ? (acc_wide + WORD_MOD) : acc_wide);

  always_comb begin
    state_d     = state_q;
    pc_en       = 1'b0;
    pc_d        = pc_q;
    mar_en      = 1'b0;
    mar_d       = mar_q;
    mdr_en      = 1'b0;
    mdr_d       = mdr_q;
    ir_en       = 1'b0;
    acc_en      = 1'b0;
    acc_d       = acc_q;
    out_en      = 1'b0;
    out_valid_d = 1'b0;
    wr_pend_d   = 1'b0;
    alu_sub     = 1'b0;
    mem_raddr   = pc_q;
    unique case (state_q)
      ST_F1: begin
        mar_en  = 1'b1;
        mar_d   = pc_q;
        mdr_en  = 1'b1;
        mdr_d   = mem_rdata;
        state_d = ST_F2;
      end
      ST_F2: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        pc_d    = pc_inc;
        state_d = ST_X1;
      end
      ST_X1: begin
        mem_raddr = dec_addr;
        unique case (dec_op)
          OP_ADD, OP_SUB, OP_LOAD: begin
            mar_en  = 1'b1;
            mar_d   = dec_addr;
            mdr_en  = 1'b1;
            mdr_d   = mem_rdata;
            state_d = ST_X2;
          end
          OP_STORE: begin
            mar_en    = 1'b1;
            mar_d     = dec_addr;
            mdr_en    = 1'b1;
            mdr_d     = store_word;
            wr_pend_d = 1'b1;
            state_d   = ST_F1;
          end
          OP_BRGE: begin
            if (!acc_q[ACC_W-1]) begin
              pc_en = 1'b1;
              pc_d  = dec_addr;
            end
            state_d = ST_F1;
          end
          OP_IN: begin
            if (in_valid) begin
              acc_en  = 1'b1;
              acc_d   = $signed(ACC_W'(clip(in_value)));
              state_d = ST_F1;
            end
          end
          OP_OUT: begin
            out_en      = 1'b1;
            out_valid_d = 1'b1;
            state_d     = ST_F1;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_X2: begin
        alu_sub = (dec_op == OP_SUB);
        acc_en  = 1'b1;
        if (dec_op == OP_LOAD) acc_d = $signed(ACC_W'(clip(mdr_q)));
        else                   acc_d = alu_res;
        state_d = ST_F1;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_F1;
      pc_q        <= '0;
      mar_q       <= '0;
      mdr_q       <= '0;
      ir_q        <= '0;
      acc_q       <= '0;
      out_q       <= '0;
      out_valid_q <= 1'b0;
      wr_pend_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_q <= out_valid_d;
      wr_pend_q   <= wr_pend_d;
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= mdr_q;
      if (acc_en) acc_q <= acc_d;
      if (out_en) out_q <= acc_q;
    end
  end

  assign halted    = (state_q == ST_HALT);
  assign in_req    = (state_q == ST_X1) && (dec_op == OP_IN);
  assign out_value = out_q;
  assign out_valid = out_valid_q;
endmodule

// File: rtl/dac_cpu_chk.sv
module dac_cpu_chk #(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7,
  parameter int ACC_W  = 11,
  parameter int LIMIT  = 999
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       pc,
  input logic signed [ACC_W-1:0] acc,
  input logic                    halted,
  input logic                    out_valid,
  input logic                    in_req,
  input logic                    in_valid
);
  p_pc_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pc) < DEPTH);

  p_acc_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc <= LIMIT) && (acc >= -LIMIT));

  p_out_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !in_valid) |=> (in_req && $stable(acc)));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !out_valid && !in_req));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_req);
endmodule

bind dac_cpu dac_cpu_chk #(
  .DEPTH  (MEM_DEPTH),
  .ADDR_W (ADDR_W),
  .ACC_W  (ACC_W),
  .LIMIT  (LIMIT)
) u_dac_cpu_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pc        (pc_q),
  .acc       (acc_q),
  .halted    (halted),
  .out_valid (out_valid),
  .in_req    (in_req),
  .in_valid  (in_valid)
);

// File: tb/test_dac_cpu.sv
`timescale 1ns/1ps
module test_dac_cpu;
  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] in_value;
  logic in_valid;
  logic in_req;
  logic signed [10:0] out_value;
  logic out_valid;
  logic halted;
  logic pl_we;
  logic [6:0] pl_addr;
  logic [9:0] pl_data;

  always #5 clk = ~clk;

  dac_cpu i_dac_cpu (
    .clk(clk), .rst_n(rst_n), .in_value(in_value), .in_valid(in_valid),
    .in_req(in_req), .out_value(out_value), .out_valid(out_valid),
    .halted(halted), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pa = 0;
  int stall_cycles = 0;
  int inreq_cycles = 0;
  bit done = 0;

  int    exp_val[$];
  string exp_tag[$];
  int    out_cyc[$];
  int    in_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_req) inreq_cycles++;
      if (out_valid) begin
        out_cyc.push_back(cyc);
        if (exp_val.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R9: unexpected output actual %0d expected none", int'(out_value));
        end else begin
          chk(exp_tag.pop_front(), int'(out_value), exp_val.pop_front());
        end
      end
    end
  end

  // input feeder
  always begin
    @(negedge clk);
    if (rst_n && in_req && !in_valid && in_q.size() > 0) begin
      repeat (stall_cycles) @(negedge clk);
      in_value = 10'(in_q.pop_front());
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
    end
  end

  task automatic put(input int a, input int v);
    pl_addr = 7'(a);
    pl_data = 10'(v);
    pl_we   = 1'b1;
    @(negedge clk);
    pl_we   = 1'b0;
  endtask

  task automatic emit(input int v);
    put(pa, v);
    pa++;
  endtask

  task automatic expect_out(input int v, input string tag);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic prep();
    rst_n = 1'b0;
    @(negedge clk);
    exp_val.delete();
    exp_tag.delete();
    out_cyc.delete();
    in_q.delete();
    stall_cycles = 0;
    inreq_cycles = 0;
    for (int i = 0; i < 100; i++) put(i, 0);
    pa = 0;
  endtask

  task automatic run(input string tag);
    int n;
    n = 0;
    rst_n = 1'b1;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " halts"}, int'(halted), 1);
    repeat (6) @(negedge clk);
    chk({tag, " all outputs seen"}, exp_val.size(), 0);
    chk({"R9 halted stays ", tag}, int'(halted), 1);
    chk({"R9 no input request ", tag}, int'(in_req), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_value = '0; in_valid = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_req in reset", int'(in_req), 0);

    // R1 R4: start at 00, accumulator 0
    prep(); emit(902); emit(0);
    expect_out(0, "R1 first output acc zero");
    run("R1");

    // R2 R4: back-to-back outputs three cycles apart
    prep(); emit(902); emit(902); emit(0);
    expect_out(0, "R4 out a"); expect_out(0, "R4 out b");
    run("R2");
    chk("R2 single-step spacing", out_cyc.size() > 1 ? out_cyc[1] - out_cyc[0] : -1, 3);

    // R5: add takes four cycles
    prep(); emit(902); emit(150); emit(902); emit(0); put(50, 0);
    expect_out(0, "R5 out a"); expect_out(0, "R5 out b");
    run("R5");
    chk("R5 add spacing", out_cyc.size() > 1 ? out_cyc[1] - out_cyc[0] : -1, 7);

    // R6: store takes three cycles
    prep(); emit(902); emit(350); emit(902); emit(0);
    expect_out(0, "R6 out a"); expect_out(0, "R6 out b");
    run("R6");
    chk("R6 store spacing", out_cyc.size() > 1 ? out_cyc[1] - out_cyc[0] : -1, 6);

    // R8: taken branch skips the halt at 02
    prep(); emit(902); emit(803); emit(0); emit(902); emit(0);
    expect_out(0, "R8 out a"); expect_out(0, "R8 taken out b");
    run("R8");
    chk("R8 branch spacing", out_cyc.size() > 1 ? out_cyc[1] - out_cyc[0] : -1, 6);

    // R2 R8: wrap from 99 to 00, branch not taken on negative
    prep(); put(0, 899); put(1, 902); put(2, 0); put(99, 250); put(50, 5);
    expect_out(-5, "R2 wrap and R8 fall-through");
    run("R2 wrap");

    // R5: saturation at both ends
    prep(); in_q.push_back(999);
    emit(901); emit(150); emit(902); emit(251); emit(251); emit(251); emit(902); emit(0);
    put(50, 999); put(51, 999);
    expect_out(999, "R5 upper clamp"); expect_out(-999, "R5 lower clamp");
    run("R5 sat");

    // R6 R7: negative store, add, load
    prep(); in_q.push_back(7); in_q.push_back(0);
    emit(901); emit(251); emit(352); emit(901); emit(152); emit(902);
    emit(552); emit(902); emit(553); emit(902); emit(0);
    put(51, 10); put(53, 123);
    expect_out(997, "R6 negative stored as 1000+acc");
    expect_out(997, "R7 load stored word");
    expect_out(123, "R7 load preloaded word");
    run("R6 R7");

    // R3: stalled input, value clamped
    prep(); in_q.push_back(1023); stall_cycles = 5;
    emit(901); emit(902); emit(0);
    expect_out(999, "R3 input clamp");
    run("R3");
    chk("R3 stall length", inreq_cycles, 6);

    // R9: unlisted opcodes halt
    prep(); emit(902); emit(400); emit(902); emit(0);
    expect_out(0, "R9 before opcode 4");
    run("R9 op4");
    prep(); emit(903); emit(902); emit(0);
    run("R9 code 903");
    prep(); emit(600); emit(902);
    run("R9 op6");

    // R10 R11 R8: self-check program, both input orders
    prep(); in_q.push_back(102); in_q.push_back(304);
    emit(901); emit(310); emit(901); emit(311); emit(210);
    emit(808); emit(510); emit(211); emit(902); emit(0);
    expect_out(202, "R11 R10 taken path");
    run("R11 a");
    chk("R3 one cycle request per input", inreq_cycles, 2);

    prep(); in_q.push_back(304); in_q.push_back(102); stall_cycles = 3;
    emit(901); emit(310); emit(901); emit(311); emit(210);
    emit(808); emit(510); emit(211); emit(902); emit(0);
    expect_out(202, "R11 R8 fall-through path");
    run("R11 b");
    chk("R3 stalled requests", inreq_cycles, 8);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule